// File: doc/BRIEF.md
# Exclusive DMA Request Source Multiplexer

This block sits between a set of peripheral request lines and the channel inputs of a DMA engine. Every channel owns one configuration word that names the peripheral line it listens to, a forwarding enable and a periodic-gating flag. The line a channel has selected reaches that channel only while its enable is set. On the lowest channels it can also be made to pass only in cycles where that channel's periodic timer pulse is present.

A peripheral line belongs to at most one channel at a time. A configuration write that names a line already held by another channel keeps the channel's old source. Software finds out by reading the word back and seeing that the source differs from the value it wrote.

The block also holds one request-enable bit per channel for the DMA engine. Software changes it by writing a channel index to a set location or to a clear location. A status location shows which channels currently receive a routed request. All access goes through a single write strobe and a combinational read port.

Top module: `rs_dmamux`

## Requirements
- R1: After reset every configuration word reads 0, the request-enable view reads 0, `ch_req_en` is 0 and `dma_req` stays 0 whatever the peripheral and trigger inputs do.
- R2: A channel whose source field (bits [3:0] of its configuration word) is 0 never asserts `dma_req`, even while peripheral line 0 is high.
- R3: A configuration write whose nonzero source is already held by a different channel leaves that channel's source field unchanged. A channel rewriting its own current source is accepted. No two channels ever hold the same nonzero source.
- R4: A channel forwards its selected line to `dma_req` only while bit 15 (forward enable) of its configuration word is 1.
- R5: On channels below NUM_PER, with bit 14 (periodic) set, the selected line passes only in cycles where that channel's `periodic_trig` bit is 1. With bit 14 clear, the trigger has no effect.
- R6: On channels at or above NUM_PER, bit 14 is not stored: it reads back 0 and the request passes without any trigger.
- R7: Reading address NUM_CH+3 (11 by default) returns the current `dma_req` vector in its low bits.
- R8: Writing index i < NUM_CH to address NUM_CH+1 (9) sets request-enable bit i. Writing it to NUM_CH+2 (10) clears that bit. Address NUM_CH (8) and `ch_req_en` show the bits one per channel. An index of NUM_CH or above changes nothing.
- R9: After a channel gives up a source by moving to another one, a different channel can take the freed source.
- R10: A configuration write whose source is rejected still updates the forward-enable and periodic bits of that word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address: 0..NUM_CH-1 configuration words, then enable view, set index, clear index, status |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Combinational read data for `reg_addr` |
| periph_req | input | NUM_SRC | Peripheral request lines; line 0 is never routed |
| periodic_trig | input | NUM_PER | Periodic timer pulse, one per low channel |
| dma_req | output | NUM_CH | Routed request per channel |
| ch_req_en | output | NUM_CH | Request-enable bit per channel, for the DMA engine |

## Verification
The assertions assume that `reg_addr` selects a decoded location or reads harmlessly as 0. They also assume that `periph_req` and `periodic_trig` are level inputs sampled at the same edge as the register port, and that `NUM_CH` is at most `DATA_W`. The bench changes inputs only on the falling edge and raises `reg_wr` for exactly one cycle per write. It uses only addresses in the map, apart from deliberate out-of-range indices on the set and clear locations. Writes that would duplicate a source are issued on purpose, so the exclusivity checks run against real rejection attempts and not only against clean configurations.

// File: rtl/rs_dmamux_pkg.sv
package rs_dmamux_pkg;

  typedef enum logic [2:0] {
    RK_NONE,
    RK_CFG,
    RK_ENVIEW,
    RK_SET,
    RK_CLR,
    RK_STAT
  } reg_kind_e;

  // Map an address onto the kind of location it selects.
  function automatic reg_kind_e decode_kind(input int unsigned addr, input int unsigned nch);
    if (addr < nch)          return RK_CFG;
    else if (addr == nch)     return RK_ENVIEW;
    else if (addr == nch + 1) return RK_SET;
    else if (addr == nch + 2) return RK_CLR;
    else if (addr == nch + 3) return RK_STAT;
    else                      return RK_NONE;
  endfunction

endpackage

// File: rtl/rs_rst_sync.sv
module rs_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_sync = stage_q[1];
endmodule

// File: rtl/rs_cfg_bank.sv
module rs_cfg_bank #(
  parameter int NUM_CH  = 8,
  parameter int NUM_PER = 4,
  parameter int SRC_W   = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NUM_CH-1:0]             cfg_we,
  input  logic [SRC_W-1:0]              wr_src,
  input  logic                          wr_en,
  input  logic                          wr_per,
  output logic [NUM_CH-1:0][SRC_W-1:0]  src_o,
  output logic [NUM_CH-1:0]             en_o,
  output logic [NUM_CH-1:0]             per_o
);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [SRC_W-1:0] src_q, src_d;
    logic             en_q, en_d;
    logic             taken;
    logic             src_ld;

    // Another channel already owns the requested nonzero source.
    always_comb begin
      taken = 1'b0;
      for (int k = 0; k < NUM_CH; k++) begin
        if (k != c && wr_src != '0 && src_o[k] == wr_src) taken = 1'b1;
      end
    end

    always_comb begin
      src_ld = cfg_we[c] && !taken;
      src_d  = wr_src;
      en_d   = wr_en;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        src_q <= '0;
        en_q  <= 1'b0;
      end else begin
        if (src_ld)    src_q <= src_d;
        if (cfg_we[c]) en_q  <= en_d;
      end
    end

    assign src_o[c] = src_q;
    assign en_o[c]  = en_q;

    if (c < NUM_PER) begin : g_per
      logic per_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         per_q <= 1'b0;
        else if (cfg_we[c]) per_q <= wr_per;
      end
      assign per_o[c] = per_q;
    end else begin : g_noper
      assign per_o[c] = 1'b0;
    end
  end

endmodule

// File: rtl/rs_req_enable.sv
module rs_req_enable #(
  parameter int NUM_CH = 8,
  parameter int DATA_W = 16,
  localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_we,
  input  logic              clr_we,
  input  logic [DATA_W-1:0] idx,
  output logic [NUM_CH-1:0] en_o
);
  logic [NUM_CH-1:0] en_q, en_d;
  logic              in_range;
  logic              ld;

  always_comb begin
    in_range = (idx < DATA_W'(NUM_CH));
    ld       = (set_we || clr_we) && in_range;
    en_d     = en_q;
    if (set_we) en_d[idx[IDX_W-1:0]] = 1'b1;
    if (clr_we) en_d[idx[IDX_W-1:0]] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  en_q <= '0;
    else if (ld) en_q <= en_d;
  end

  assign en_o = en_q;
endmodule

// File: rtl/rs_route.sv
module rs_route #(
  parameter int NUM_CH  = 8,
  parameter int NUM_SRC = 16,
  parameter int NUM_PER = 4,
  parameter int SRC_W   = 4
) (
  input  logic [NUM_SRC-1:0]            periph_req,
  input  logic [NUM_PER-1:0]            trig,
  input  logic [NUM_CH-1:0][SRC_W-1:0]  src,
  input  logic [NUM_CH-1:0]             en,
  input  logic [NUM_CH-1:0]             per,
  output logic [NUM_CH-1:0]             req
);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic line;
    logic gate;

    assign line = periph_req[src[c]];

    if (c < NUM_PER) begin : g_per
      assign gate = !per[c] || trig[c];
    end else begin : g_free
      assign gate = 1'b1;
    end

    assign req[c] = en[c] && (src[c] != '0) && line && gate;
  end

endmodule

// File: rtl/rs_dmamux.sv
module rs_dmamux
  import rs_dmamux_pkg::*;
#(
  parameter int NUM_CH  = 8,
  parameter int NUM_SRC = 16,
  parameter int NUM_PER = 4,
  parameter int DATA_W  = 16,
  localparam int ADDR_W = $clog2(NUM_CH + 4)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [DATA_W-1:0]  reg_wdata,
  output logic [DATA_W-1:0]  reg_rdata,
  input  logic [NUM_SRC-1:0] periph_req,
  input  logic [NUM_PER-1:0] periodic_trig,
  output logic [NUM_CH-1:0]  dma_req,
  output logic [NUM_CH-1:0]  ch_req_en
);
  localparam int SRC_W  = $clog2(NUM_SRC);
  localparam int IDX_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
  localparam int EN_BIT = DATA_W - 1;
  localparam int PER_BIT = DATA_W - 2;

  logic                         rst_n_s;
  reg_kind_e                    kind;
  logic [NUM_CH-1:0]            cfg_we;
  logic [NUM_CH-1:0][SRC_W-1:0] cfg_src;
  logic [NUM_CH-1:0]            cfg_en;
  logic [NUM_CH-1:0]            cfg_per;

  rs_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  assign kind = decode_kind(int'(reg_addr), NUM_CH);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_we
    assign cfg_we[c] = reg_wr && (kind == RK_CFG) && (reg_addr == ADDR_W'(c));
  end

  rs_cfg_bank #(.NUM_CH(NUM_CH), .NUM_PER(NUM_PER), .SRC_W(SRC_W)) u_cfg (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .cfg_we (cfg_we),
    .wr_src (reg_wdata[SRC_W-1:0]),
    .wr_en  (reg_wdata[EN_BIT]),
    .wr_per (reg_wdata[PER_BIT]),
    .src_o  (cfg_src),
    .en_o   (cfg_en),
    .per_o  (cfg_per)
  );

  rs_req_enable #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_ren (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .set_we (reg_wr && kind == RK_SET),
    .clr_we (reg_wr && kind == RK_CLR),
    .idx    (reg_wdata),
    .en_o   (ch_req_en)
  );

  rs_route #(.NUM_CH(NUM_CH), .NUM_SRC(NUM_SRC), .NUM_PER(NUM_PER), .SRC_W(SRC_W)) u_route (
    .periph_req (periph_req),
    .trig       (periodic_trig),
    .src        (cfg_src),
    .en         (cfg_en),
    .per        (cfg_per),
    .req        (dma_req)
  );

  always_comb begin
    reg_rdata = '0;
    case (kind)
      RK_CFG: begin
        reg_rdata[SRC_W-1:0] = cfg_src[reg_addr[IDX_W-1:0]];
        reg_rdata[PER_BIT]   = cfg_per[reg_addr[IDX_W-1:0]];
        reg_rdata[EN_BIT]    = cfg_en[reg_addr[IDX_W-1:0]];
      end
      RK_ENVIEW: reg_rdata[NUM_CH-1:0] = ch_req_en;
      RK_STAT:   reg_rdata[NUM_CH-1:0] = dma_req;
      default:   reg_rdata = '0;
    endcase
  end

endmodule

// File: rtl/rs_dmamux_chk.sv
module rs_dmamux_chk #(
  parameter int NUM_CH  = 8,
  parameter int NUM_PER = 4,
  parameter int DATA_W  = 16,
  parameter int SRC_W   = 4,
  parameter int ADDR_W  = 4
) (
  input logic                         clk,
  input logic                         rst_n_s,
  input logic                         reg_wr,
  input logic [ADDR_W-1:0]            reg_addr,
  input logic [DATA_W-1:0]            reg_wdata,
  input logic [DATA_W-1:0]            reg_rdata,
  input logic [NUM_PER-1:0]           periodic_trig,
  input logic [NUM_CH-1:0]            dma_req,
  input logic [NUM_CH-1:0]            ch_req_en,
  input logic [NUM_CH-1:0][SRC_W-1:0] cfg_src,
  input logic [NUM_CH-1:0]            cfg_en,
  input logic [NUM_CH-1:0]            cfg_per
);
  localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
  localparam logic [ADDR_W-1:0] A_SET  = ADDR_W'(NUM_CH + 1);
  localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(NUM_CH + 2);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(NUM_CH + 3);

  logic              dup;
  logic [NUM_CH-1:0] zero_src;

  always_comb begin
    dup = 1'b0;
    for (int i = 0; i < NUM_CH; i++) begin
      zero_src[i] = (cfg_src[i] == '0);
      for (int j = i + 1; j < NUM_CH; j++) begin
        if (cfg_src[i] != '0 && cfg_src[i] == cfg_src[j]) dup = 1'b1;
      end
    end
  end

  assert_src_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n_s)
    !dup);

  assert_no_source_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n_s)
    (dma_req & zero_src) == '0);

  assert_forward_needs_enable_R4: assert property (@(posedge clk) disable iff (!rst_n_s)
    (dma_req & ~cfg_en) == '0);

  assert_periodic_gate_R5: assert property (@(posedge clk) disable iff (!rst_n_s)
    (dma_req[NUM_PER-1:0] & cfg_per[NUM_PER-1:0] & ~periodic_trig) == '0);

  assert_status_view_R7: assert property (@(posedge clk) disable iff (!rst_n_s)
    (reg_addr == A_STAT) |-> (reg_rdata[NUM_CH-1:0] == dma_req));

  assert_set_index_R8: assert property (@(posedge clk) disable iff (!rst_n_s)
    (reg_wr && reg_addr == A_SET && reg_wdata < DATA_W'(NUM_CH))
      |=> ch_req_en[$past(reg_wdata[IDX_W-1:0])]);

  assert_clear_index_R8: assert property (@(posedge clk) disable iff (!rst_n_s)
    (reg_wr && reg_addr == A_CLR && reg_wdata < DATA_W'(NUM_CH))
      |=> !ch_req_en[$past(reg_wdata[IDX_W-1:0])]);

  assert_bad_index_R8: assert property (@(posedge clk) disable iff (!rst_n_s)
    (reg_wr && (reg_addr == A_SET || reg_addr == A_CLR) && reg_wdata >= DATA_W'(NUM_CH))
      |=> $stable(ch_req_en));

endmodule

bind rs_dmamux rs_dmamux_chk #(
  .NUM_CH (NUM_CH),
  .NUM_PER(NUM_PER),
  .DATA_W (DATA_W),
  .SRC_W  (SRC_W),
  .ADDR_W (ADDR_W)
) u_chk (
  .clk          (clk),
  .rst_n_s      (rst_n_s),
  .reg_wr       (reg_wr),
  .reg_addr     (reg_addr),
  .reg_wdata    (reg_wdata),
  .reg_rdata    (reg_rdata),
  .periodic_trig(periodic_trig),
  .dma_req      (dma_req),
  .ch_req_en    (ch_req_en),
  .cfg_src      (cfg_src),
  .cfg_en       (cfg_en),
  .cfg_per      (cfg_per)
);

// File: tb/test_rs_dmamux.sv
module test_rs_dmamux;
  localparam int NCH = 8;
  localparam int NSRC = 16;
  localparam int NPER = 4;
  localparam int DW = 16;
  localparam int AW = 4;
  localparam int A_EN = 8, A_SET = 9, A_CLR = 10, A_STAT = 11;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            reg_wr;
  logic [AW-1:0]   reg_addr;
  logic [DW-1:0]   reg_wdata;
  logic [DW-1:0]   reg_rdata;
  logic [NSRC-1:0] periph_req;
  logic [NPER-1:0] periodic_trig;
  logic [NCH-1:0]  dma_req;
  logic [NCH-1:0]  ch_req_en;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  rs_dmamux i_rs_dmamux (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .periph_req(periph_req),
    .periodic_trig(periodic_trig), .dma_req(dma_req), .ch_req_en(ch_req_en)
  );

  // {periph_req, periodic_trig, expected dma_req}
  localparam logic [27:0] VEC [11] = '{
    {16'h0000, 4'h0, 8'h00},
    {16'h0008, 4'h0, 8'h00},
    {16'h0008, 4'h1, 8'h01},
    {16'h0020, 4'h0, 8'h02},
    {16'h0080, 4'h0, 8'h00},
    {16'h0200, 4'h0, 8'h20},
    {16'h0001, 4'hF, 8'h00},
    {16'hFFFF, 4'h0, 8'h22},
    {16'hFFFF, 4'hF, 8'h2B},
    {16'h0800, 4'h8, 8'h08},
    {16'h0800, 4'h1, 8'h00}
  };

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input int a, input logic [DW-1:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = AW'(a); reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input int a, output logic [DW-1:0] d);
    reg_addr = AW'(a);
    #1 d = reg_rdata;
  endtask

  task automatic drive(input logic [NSRC-1:0] p, input logic [NPER-1:0] t);
    @(negedge clk);
    periph_req = p; periodic_trig = t;
    #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [DW-1:0] d;
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    periph_req = '0; periodic_trig = '0;
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    for (int c = 0; c < NCH; c++) begin
      rd(c, d); chk("R1 cfg", d, 0);
    end
    rd(A_EN, d); chk("R1 enview", d, 0);
    chk("R1 ch_req_en", ch_req_en, 0);
    drive('1, '1); chk("R1 dma_req", dma_req, 0);

    // configuration for the vector walk
    wr(0, 16'hC003);
    wr(1, 16'h8005);
    wr(2, 16'h0007);
    wr(3, 16'hC00B);
    wr(5, 16'h8009);
    wr(7, 16'h8000);

    // vector walk: R2 R4 R5 R7
    foreach (VEC[i]) begin
      drive(VEC[i][27:12], VEC[i][11:8]);
      chk("R2/R4/R5 dma_req", dma_req, VEC[i][7:0]);
      rd(A_STAT, d);
      chk("R7 status", d, {8'h00, VEC[i][7:0]});
    end

    // R3 rejection, R10 enable still written
    wr(4, 16'h8005);
    rd(4, d); chk("R3 R10 rejected src", d, 16'h8000);
    drive(16'h0020, 4'h0); chk("R3 owner only", dma_req, 8'h02);
    wr(1, 16'h8005);
    rd(1, d); chk("R3 self rewrite", d, 16'h8005);

    // R9 release and retake
    wr(1, 16'h8006);
    wr(4, 16'h8005);
    rd(4, d); chk("R9 retake", d, 16'h8005);
    drive(16'h0020, 4'h0); chk("R9 new owner", dma_req, 8'h10);

    // R6 no periodic on high channels
    wr(5, 16'hC009);
    rd(5, d); chk("R6 per bit dropped", d, 16'h8009);
    drive(16'h0200, 4'h0); chk("R6 passes untriggered", dma_req, 8'h20);

    // R5 periodic off: trigger irrelevant
    wr(0, 16'h8003);
    drive(16'h0008, 4'h0); chk("R5 periodic off", dma_req, 8'h01);

    // R4 forward enable cleared
    wr(1, 16'h0006);
    drive(16'h0040, 4'h0); chk("R4 disabled", dma_req, 8'h00);
    rd(1, d); chk("R4 readback", d, 16'h0006);

    // R8 set/clear by index
    wr(A_SET, 16'd2);
    wr(A_SET, 16'd7);
    rd(A_EN, d); chk("R8 set view", d, 16'h0084);
    chk("R8 port", ch_req_en, 8'h84);
    wr(A_CLR, 16'd2);
    rd(A_EN, d); chk("R8 clear", d, 16'h0080);
    wr(A_SET, 16'd8);
    wr(A_CLR, 16'd9);
    rd(A_EN, d); chk("R8 out of range", d, 16'h0080);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule